// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This peripheral guards a processor against stalls. A down counter of configurable width runs on the block's clock, advancing only when a separate timer-clock enable is high. When the counter reaches zero it reloads and flags a pending interrupt. If software fails to service that interrupt and the counter expires a second time, the block issues a reset request.

Software drives the block through a small word-addressed register port with a write strobe, and a read strobe whose data appears one cycle later. A key-protected lock keeps runaway code from changing the configuration. A debug stall lets the count freeze while an attached processor is halted. After it issues a reset request, the block returns to its power-on state on its own.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset, irq and rst_req are low, reading COUNT (address 1) returns all ones, CTRL (address 2) reads 0, and LOCK (address 5) reads 0.
- R2: A write to LOAD (address 0) sets the counter to the written value at once. While CTRL bit0 (run) is set and tick_en is high, the counter drops by one per clock. A read returns the value held at the clock edge that samples rd_en.
- R3: When an advancing counter is at zero, the next edge reloads it from LOAD and sets the pending flag (STATUS address 4, bit0).
- R4: irq equals the pending flag ANDed with CTRL bit3 (unmask), so with bit3 clear irq stays low while STATUS bit0 reads 1.
- R5: A second expiry while pending is set, with CTRL bit1 (reset enable) set, drives rst_req high for exactly one cycle. On that same edge, every register returns to its R1 state.
- R6: With CTRL bit1 clear, a second expiry raises no reset request. The counter reloads and pending stays set.
- R7: Any write to ICLR (address 3) clears pending and reloads the counter from LOAD.
- R8: Writing 0x1ACCE551 to LOCK unlocks and any other value locks, and LOCK reads 1 when locked. While locked, writes to LOAD, CTRL and ICLR are ignored.
- R9: When CTRL bit2 (stall enable) and cpu_halt are both high, the counter holds. With bit2 clear, cpu_halt has no effect.
- R10: With tick_en low, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Timer clock enable |
| cpu_halt | input | 1 | Debug halt indication from processor |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register word address |
| wr_data | input | WIDTH | Write data |
| rd_data | output | WIDTH | Read data, valid the cycle after rd_en |
| irq | output | 1 | Masked interrupt |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The properties assume that only one register access occurs per cycle and that addr is stable whenever a strobe is high. They also assume that inputs change only between clock edges. The hold properties exclude cycles that carry an accepted LOAD or ICLR write, or a self-reset, because those cycles legitimately move the count. The bench drives every strobe and control input at the falling edge, issues one access at a time, and reads back through the register port, so every stimulus stays inside these assumptions.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W = 3;
  localparam int CTRL_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_LOAD   = 3'd0,
    A_COUNT  = 3'd1,
    A_CTRL   = 3'd2,
    A_ICLR   = 3'd3,
    A_STATUS = 3'd4,
    A_LOCK   = 3'd5
  } reg_addr_e;

  // bit3 unmask, bit2 stall enable, bit1 reset enable, bit0 run
  typedef struct packed {
    logic irq_unmask;
    logic stall_en;
    logic rst_en;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/wdog_lock.sv
module wdog_lock #(
  parameter int W = 32,
  parameter logic [W-1:0] KEY = 'h1ACCE551
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wipe,
  input  logic         we,
  input  logic [W-1:0] wr_data,
  output logic         locked
);
  always_ff @(posedge clk) begin
    if (rst || wipe) begin
      locked <= 1'b0;
    end else if (we) begin
      locked <= (wr_data != KEY);
    end
  end
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wipe,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wr_data,
  input  logic              locked,
  input  logic [W-1:0]      count,
  input  logic              pending,
  input  logic              irq,
  output logic [W-1:0]      load_q,
  output ctrl_t             ctrl_q,
  output logic              ld_we,
  output logic              clr_we,
  output logic              lock_we,
  output logic [W-1:0]      rd_data
);
  logic ctrl_we;

  always_comb begin
    ld_we   = wr_en && !locked && (addr == A_LOAD);
    ctrl_we = wr_en && !locked && (addr == A_CTRL);
    clr_we  = wr_en && !locked && (addr == A_ICLR);
    lock_we = wr_en && (addr == A_LOCK);
  end

  always_ff @(posedge clk) begin
    if (rst || wipe) begin
      load_q <= '1;
      ctrl_q <= '0;
    end else begin
      if (ld_we)   load_q <= wr_data;
      if (ctrl_we) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      case (addr)
        A_LOAD:   rd_data <= load_q;
        A_COUNT:  rd_data <= count;
        A_CTRL:   rd_data <= {{(W-CTRL_W){1'b0}}, ctrl_q};
        A_STATUS: rd_data <= {{(W-2){1'b0}}, irq, pending};
        A_LOCK:   rd_data <= {{(W-1){1'b0}}, locked};
        default:  rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wipe,
  input  logic         tick_en,
  input  logic         run,
  input  logic         stall_en,
  input  logic         cpu_halt,
  input  logic         reload,
  input  logic [W-1:0] reload_val,
  input  logic [W-1:0] load_q,
  output logic [W-1:0] count,
  output logic         timeout
);
  logic advance;

  always_comb begin
    advance = tick_en && run && !(stall_en && cpu_halt);
    timeout = advance && (count == '0);
  end

  always_ff @(posedge clk) begin
    if (rst || wipe) begin
      count <= '1;
    end else if (reload) begin
      count <= reload_val;
    end else if (timeout) begin
      count <= load_q;
    end else if (advance) begin
      count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/wdog_stage.sv
module wdog_stage (
  input  logic clk,
  input  logic rst,
  input  logic timeout,
  input  logic clr,
  input  logic rst_en,
  input  logic unmask,
  output logic pending,
  output logic irq,
  output logic rst_req,
  output logic wipe
);
  always_comb begin
    wipe = timeout && pending && rst_en && !clr;
    irq  = pending && unmask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= wipe;
      if (wipe || clr) begin
        pending <= 1'b0;
      end else if (timeout) begin
        pending <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
  import wdog_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter logic [WIDTH-1:0] UNLOCK_KEY = 'h1ACCE551
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              cpu_halt,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wr_data,
  output logic [WIDTH-1:0]  rd_data,
  output logic              irq,
  output logic              rst_req
);
  logic [WIDTH-1:0] load_q;
  logic [WIDTH-1:0] count;
  logic [WIDTH-1:0] reload_val;
  ctrl_t            ctrl;
  logic             locked;
  logic             ld_we;
  logic             clr_we;
  logic             lock_we;
  logic             timeout;
  logic             pending;
  logic             wipe;

  assign reload_val = ld_we ? wr_data : load_q;

  wdog_lock #(.W(WIDTH), .KEY(UNLOCK_KEY)) u_lock (
    .clk(clk), .rst(rst), .wipe(wipe), .we(lock_we),
    .wr_data(wr_data), .locked(locked)
  );

  wdog_regs #(.W(WIDTH)) u_regs (
    .clk(clk), .rst(rst), .wipe(wipe), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .locked(locked), .count(count),
    .pending(pending), .irq(irq), .load_q(load_q), .ctrl_q(ctrl),
    .ld_we(ld_we), .clr_we(clr_we), .lock_we(lock_we), .rd_data(rd_data)
  );

  wdog_counter #(.W(WIDTH)) u_cnt (
    .clk(clk), .rst(rst), .wipe(wipe), .tick_en(tick_en), .run(ctrl.run),
    .stall_en(ctrl.stall_en), .cpu_halt(cpu_halt),
    .reload(ld_we || clr_we), .reload_val(reload_val), .load_q(load_q),
    .count(count), .timeout(timeout)
  );

  wdog_stage u_stage (
    .clk(clk), .rst(rst), .timeout(timeout), .clr(clr_we),
    .rst_en(ctrl.rst_en), .unmask(ctrl.irq_unmask),
    .pending(pending), .irq(irq), .rst_req(rst_req), .wipe(wipe)
  );
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker
  import wdog_pkg::*;
#(
  parameter int W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_en,
  input logic              cpu_halt,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              locked,
  input ctrl_t             ctrl,
  input logic [W-1:0]      count,
  input logic              pending,
  input logic              irq,
  input logic              rst_req,
  input logic              ld_we,
  input logic              clr_we,
  input logic              wipe
);
  logic quiet;
  assign quiet = !ld_we && !clr_we && !wipe;

  assert_irq_after_zero_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(pending) |-> ($past(count) == '0));

  assert_irq_masked_R4: assert property (@(posedge clk) disable iff (rst)
    !ctrl.irq_unmask |-> !irq);

  assert_rst_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);

  assert_rst_after_pending_R5: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> $past(pending));

  assert_no_rst_disabled_R6: assert property (@(posedge clk) disable iff (rst)
    !ctrl.rst_en |=> !rst_req);

  assert_clear_pending_R7: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> !pending);

  assert_lock_ctrl_R8: assert property (@(posedge clk) disable iff (rst)
    (locked && wr_en && addr == A_CTRL && !wipe) |=> $stable(ctrl));

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (ctrl.stall_en && cpu_halt && quiet) |=> $stable(count));

  assert_tick_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && quiet) |=> $stable(count));
endmodule

bind wdog_two_stage wdog_checker #(.W(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .tick_en(tick_en), .cpu_halt(cpu_halt),
  .wr_en(wr_en), .addr(addr), .locked(locked), .ctrl(ctrl),
  .count(count), .pending(pending), .irq(irq), .rst_req(rst_req),
  .ld_we(ld_we), .clr_we(clr_we), .wipe(wipe)
);

// File: tb/tb_wdog_two_stage.sv
`timescale 1ns/1ps
module tb_wdog_two_stage;
  localparam int W = 32;
  localparam logic [2:0] LOAD = 3'd0, COUNT = 3'd1, CTRL = 3'd2,
                         ICLR = 3'd3, STATUS = 3'd4, LOCK = 3'd5;
  localparam logic [W-1:0] KEY = 32'h1ACCE551;

  logic clk = 1'b0;
  logic rst, tick_en, cpu_halt, wr_en, rd_en, irq, rst_req;
  logic [2:0] addr;
  logic [W-1:0] wr_data, rd_data;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  wdog_two_stage dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .cpu_halt(cpu_halt),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .irq(irq), .rst_req(rst_req)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // all tasks begin and end at a falling edge
  task automatic do_reset();
    rst = 1'b1; tick_en = 1'b1; cpu_halt = 1'b0;
    wr_en = 1'b0; rd_en = 1'b0; addr = '0; wr_data = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    d = rd_data;
    rd_en = 1'b0;
  endtask

  task automatic t_reset_state();
    logic [W-1:0] v;
    @(negedge clk);
    do_reset();
    check("R1 irq", W'(irq), 0);
    check("R1 rst_req", W'(rst_req), 0);
    rd(COUNT, v); check("R1 count", v, '1);
    rd(CTRL, v);  check("R1 ctrl", v, 0);
    rd(LOCK, v);  check("R1 lock", v, 0);
  endtask

  task automatic t_countdown();
    logic [W-1:0] v;
    do_reset();
    wr(CTRL, 32'h1);
    wr(LOAD, 32'd10);
    rd(COUNT, v); check("R2 load", v, 32'd10);
    rd(COUNT, v); check("R2 decrement", v, 32'd9);
  endtask

  task automatic t_first_timeout();
    logic [W-1:0] v;
    do_reset();
    wr(CTRL, 32'h9);
    wr(LOAD, 32'd5);
    repeat (5) @(negedge clk);
    check("R3 before expiry", W'(irq), 0);
    @(negedge clk);
    check("R3 irq", W'(irq), 1);
    rd(COUNT, v); check("R3 reload", v, 32'd5);
  endtask

  task automatic t_mask_and_clear();
    logic [W-1:0] v;
    do_reset();
    wr(CTRL, 32'h1);
    wr(LOAD, 32'd2);
    repeat (3) @(negedge clk);
    check("R4 masked irq", W'(irq), 0);
    rd(STATUS, v); check("R4 raw pending", v & 32'h1, 32'h1);
    wr(CTRL, 32'h9);
    check("R4 unmasked irq", W'(irq), 1);
    wr(LOAD, 32'd20);
    wr(ICLR, 32'h0);
    check("R7 irq cleared", W'(irq), 0);
    rd(COUNT, v); check("R7 reload", v, 32'd20);
    rd(STATUS, v); check("R7 pending cleared", v & 32'h1, 32'h0);
  endtask

  task automatic t_second_reset();
    logic [W-1:0] v;
    do_reset();
    wr(CTRL, 32'hB);
    wr(LOAD, 32'd3);
    repeat (4) @(negedge clk);
    check("R5 first irq", W'(irq), 1);
    repeat (3) @(negedge clk);
    check("R5 no early reset", W'(rst_req), 0);
    @(negedge clk);
    check("R5 reset pulse", W'(rst_req), 1);
    check("R5 irq cleared by wipe", W'(irq), 0);
    @(negedge clk);
    check("R5 pulse width", W'(rst_req), 0);
    rd(CTRL, v);  check("R5 ctrl default", v, 0);
    rd(COUNT, v); check("R5 count default", v, '1);
  endtask

  task automatic t_second_no_reset();
    logic [W-1:0] v;
    do_reset();
    wr(CTRL, 32'h9);
    wr(LOAD, 32'd3);
    repeat (8) @(negedge clk);
    check("R6 no reset", W'(rst_req), 0);
    check("R6 still pending", W'(irq), 1);
    rd(COUNT, v); check("R6 reload", v, 32'd3);
  endtask

  task automatic t_lock();
    logic [W-1:0] v;
    do_reset();
    wr(LOAD, 32'd7);
    wr(LOCK, 32'h0);
    rd(LOCK, v); check("R8 locked", v, 1);
    wr(LOAD, 32'd50);
    wr(CTRL, 32'h1);
    rd(COUNT, v); check("R8 load ignored", v, 32'd7);
    rd(CTRL, v);  check("R8 ctrl ignored", v, 0);
    wr(LOCK, KEY);
    rd(LOCK, v); check("R8 unlocked", v, 0);
    wr(CTRL, 32'h9);
    wr(LOAD, 32'd2);
    repeat (3) @(negedge clk);
    check("R8 irq set", W'(irq), 1);
    wr(LOCK, KEY + 1);
    wr(ICLR, 32'h0);
    check("R8 clear ignored", W'(irq), 1);
    wr(LOCK, KEY);
    wr(ICLR, 32'h0);
    check("R8 clear after unlock", W'(irq), 0);
  endtask

  task automatic t_stall();
    logic [W-1:0] a, b;
    do_reset();
    wr(CTRL, 32'h5);
    cpu_halt = 1'b1;
    wr(LOAD, 32'd100);
    rd(COUNT, a); check("R9 stall hold", a, 32'd100);
    rd(COUNT, b); check("R9 stall hold 2", b, 32'd100);
    cpu_halt = 1'b0;
    rd(COUNT, a);
    rd(COUNT, b); check("R9 resume", b, a - 1);
    wr(CTRL, 32'h1);
    cpu_halt = 1'b1;
    rd(COUNT, a);
    rd(COUNT, b); check("R9 halt ignored", b, a - 1);
    cpu_halt = 1'b0;
  endtask

  task automatic t_tick_enable();
    logic [W-1:0] v;
    do_reset();
    wr(CTRL, 32'h1);
    tick_en = 1'b0;
    wr(LOAD, 32'd40);
    rd(COUNT, v); check("R10 hold", v, 32'd40);
    repeat (5) @(negedge clk);
    rd(COUNT, v); check("R10 hold later", v, 32'd40);
    tick_en = 1'b1;
    rd(COUNT, v);
    rd(COUNT, v); check("R10 resume", v, 32'd39);
  endtask

  initial begin
    t_reset_state();
    t_countdown();
    t_first_timeout();
    t_mask_and_clear();
    t_second_reset();
    t_second_no_reset();
    t_lock();
    t_stall();
    t_tick_enable();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog (R1..): actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule